// File: doc/BRIEF.md
# Protected Domain Call and Return Sequencer

This block performs cross-domain procedure calls and returns for a capability machine that has no privileged mode. A call presents an enter capability for the root block of a protection domain, plus an offset into that block. The sequencer checks that the enter capability permits entry and that the offset falls inside the block. It then fetches the single word at that offset and confirms that the word is an execute capability.

After these checks, the caller's program counter, domain root register and code register are saved as a three-word frame on a per-process dump stack. The sequencer then installs the new domain. The root register receives a read-only capability for the called block. The code register receives the fetched capability. The program counter is set to zero.

A return pops the frame in reverse order and restores all three values. The dump stack pointer lives inside the sequencer. A push beyond the stack's capacity, or a pop from an empty stack, is refused with a fault. Any refused operation leaves registers, counter and stack exactly as they were.

The block sits between the processor's memory port, its capability register file and its program counter. It only ever writes register indices 6 (domain root) and 7 (current code). Registers 0 through 4 pass through a call or return untouched.

Top module: `domain_call_seq`

## Requirements
- R1: A call whose enter capability lacks the enter right (rights bit 3) is refused with a fault, and so is a call whose offset is not below the capability's limit; neither issues a memory access.
- R2: A call that passes R1 reads exactly one word of the root block, at base plus offset; if rights bit 0 (execute) of that word is clear, the call is refused with a fault.
- R3: A successful call writes the caller's PC (zero-extended) at stack word sp, the old root (register 6) at sp+1 and the old code (register 7) at sp+2, where stack words sit at STK_BASE+index, and then advances sp by 3.
- R4: After a successful call, register 6 holds rights 6'b100000 (read-capability only) with the enter capability's base and limit, register 7 holds the fetched word, and the PC is 0. A capability word is {rights[5:0], base[ADDR_W-1:0], limit[ADDR_W-1:0]}.
- R5: A return reads register 7 from sp-1, register 6 from sp-2 and the PC from sp-3 (low ADDR_W bits), restoring the state saved by the matching call, and reduces sp by 3.
- R6: A call when STK_FRAMES frames are held, or a return with no frame held, is refused with a fault; no refused operation changes registers, PC or stack depth.
- R7: Only register indices 6 and 7 are ever written; registers 0 to 4 are never written.
- R8: From the clock edge that samples op_start, done pulses for one cycle after 6 edges for a successful call, 3 for a return, 2 for a call refused on the execute check, and 1 for any other refusal; busy is high from that edge until done.
- R9: Reset (synchronous, active low) returns the sequencer to idle with an empty dump stack, with no memory request and no register write pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start an operation (sampled when idle) |
| op_ret | input | 1 | 1 = return, 0 = call |
| enter_cap | input | 6+2*ADDR_W | Enter capability for the target root block |
| call_off | input | ADDR_W | Offset into the root block |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a refusal (valid with done) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 6+2*ADDR_W | Memory write data |
| mem_rdata | input | 6+2*ADDR_W | Memory read data, valid in the request cycle |
| cur_root | input | 6+2*ADDR_W | Current content of register 6 |
| cur_code | input | 6+2*ADDR_W | Current content of register 7 |
| cur_pc | input | ADDR_W | Current program counter |
| cap_wr_en | output | 1 | Capability register write strobe |
| cap_wr_sel | output | 3 | Capability register index to write |
| cap_wr_data | output | 6+2*ADDR_W | Capability register write data |
| pc_wr_en | output | 1 | Program counter write strobe |
| pc_wr_data | output | ADDR_W | Program counter write data |

## Verification
The bench builds the block with STK_FRAMES = 2, ADDR_W = 8 and STK_BASE = 0xC0. With only two frames, a third nested call reaches the overflow refusal. Unwinding both frames then reaches the underflow refusal, all within a short vector table. The same table crosses every refusal path: missing enter right, offset equal to the limit, and a non-executable target word. Each refusal sits between successful calls, so a refusal that disturbed the stack would corrupt the frames popped later. A directed reset in the middle of a call shows that the stack comes back empty.

// File: rtl/dcs_pkg.sv
// Package: shared constants and state encoding for the domain call sequencer.
// Assumes a capability word laid out as {rights[5:0], base, limit}.
package dcs_pkg;
    localparam int RIGHTS_W    = 6;
    localparam int RT_EXEC     = 0;
    localparam int RT_WDATA    = 1;
    localparam int RT_RDATA    = 2;
    localparam int RT_ENTER    = 3;
    localparam int RT_WCAP     = 4;
    localparam int RT_RCAP     = 5;
    localparam int FRAME_WORDS = 3;
    localparam logic [2:0] REG_ROOT = 3'd6;
    localparam logic [2:0] REG_CODE = 3'd7;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_PUSH_PC, S_PUSH_RT, S_PUSH_CD,
        S_LOAD_RT, S_LOAD_CD, S_POP_CD, S_POP_RT, S_POP_PC, S_FAULT
    } seq_state_e;
endpackage

// File: rtl/dcs_call_gate.sv
// Module: dcs_call_gate
// Decodes an enter capability and judges whether a call may proceed.
// Assumes: pure combinational; the caller registers whatever it keeps.
module dcs_call_gate
    import dcs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [RIGHTS_W+2*ADDR_W-1:0] enter_cap,
    input  logic [ADDR_W-1:0]            call_off,
    input  logic                         code_exec_bit,
    output logic                         pre_ok,
    output logic                         exec_ok,
    output logic [ADDR_W-1:0]            fetch_addr,
    output logic [RIGHTS_W+2*ADDR_W-1:0] root_cap
);
    localparam int CAP_W = RIGHTS_W + 2 * ADDR_W;

    logic [RIGHTS_W-1:0] rights;
    logic [ADDR_W-1:0]   base;
    logic [ADDR_W-1:0]   limit;
    logic [RIGHTS_W-1:0] root_rights;

    // Split the enter capability into its fields.
    always_comb begin
        rights = enter_cap[CAP_W-1 -: RIGHTS_W];
        base   = enter_cap[2*ADDR_W-1:ADDR_W];
        limit  = enter_cap[ADDR_W-1:0];
    end

    // Judge the call and form the read-only root capability.
    always_comb begin
        pre_ok      = rights[RT_ENTER] && (call_off < limit);
        exec_ok     = code_exec_bit;
        fetch_addr  = base + call_off;
        root_rights = '0;
        root_rights[RT_RCAP] = 1'b1;
        root_cap    = {root_rights, base, limit};
    end
endmodule

// File: rtl/dcs_dump_ptr.sv
// Module: dcs_dump_ptr
// Holds the dump stack pointer in words; moves by one frame per push/pop.
// Assumes the sequencer never pushes when full nor pops when empty.
module dcs_dump_ptr
    import dcs_pkg::*;
#(
    parameter int STK_FRAMES = 4,
    localparam int STK_WORDS = STK_FRAMES * FRAME_WORDS,
    localparam int SP_W      = $clog2(STK_WORDS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp,
    output logic            full,
    output logic            empty
);
    // Advance or retreat the pointer by one frame; reset empties the stack.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= '0;
        else if (push)
            sp <= sp + SP_W'(FRAME_WORDS);
        else if (pop)
            sp <= sp - SP_W'(FRAME_WORDS);
    end

    // Derive the capacity flags from the pointer.
    always_comb begin
        full  = sp > SP_W'(STK_WORDS - FRAME_WORDS);
        empty = sp < SP_W'(FRAME_WORDS);
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R6
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(STK_WORDS));
endmodule

// File: rtl/domain_call_seq.sv
// Module: domain_call_seq
// Sequences a protected call (check, fetch, three pushes, two register loads)
// and a return (three pops). Assumes mem_rdata is valid in the cycle of a
// read request, and that cur_root/cur_code/cur_pc reflect writes the cycle after.
module domain_call_seq
    import dcs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int STK_FRAMES = 4,
    parameter int STK_BASE   = 192,
    localparam int CAP_W     = RIGHTS_W + 2 * ADDR_W,
    localparam int STK_WORDS = STK_FRAMES * FRAME_WORDS,
    localparam int SP_W      = $clog2(STK_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_ret,
    input  logic [CAP_W-1:0]  enter_cap,
    input  logic [ADDR_W-1:0] call_off,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CAP_W-1:0]  mem_wdata,
    input  logic [CAP_W-1:0]  mem_rdata,
    input  logic [CAP_W-1:0]  cur_root,
    input  logic [CAP_W-1:0]  cur_code,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              cap_wr_en,
    output logic [2:0]        cap_wr_sel,
    output logic [CAP_W-1:0]  cap_wr_data,
    output logic              pc_wr_en,
    output logic [ADDR_W-1:0] pc_wr_data
);
    localparam logic [ADDR_W-1:0] STK_ORG = ADDR_W'(STK_BASE);

    seq_state_e        state, state_nx;
    logic [CAP_W-1:0]  root_q, code_q;
    logic [ADDR_W-1:0] fetch_q;
    logic              pre_ok, exec_ok;
    logic [ADDR_W-1:0] gate_addr;
    logic [CAP_W-1:0]  gate_root;
    logic [SP_W-1:0]   sp;
    logic              stk_full, stk_empty, push, pop;
    logic [ADDR_W-1:0] slot;

    dcs_call_gate #(.ADDR_W(ADDR_W)) u_gate (
        .enter_cap     (enter_cap),
        .call_off      (call_off),
        .code_exec_bit (mem_rdata[CAP_W-RIGHTS_W+RT_EXEC]),
        .pre_ok        (pre_ok),
        .exec_ok       (exec_ok),
        .fetch_addr    (gate_addr),
        .root_cap      (gate_root)
    );

    dcs_dump_ptr #(.STK_FRAMES(STK_FRAMES)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .sp    (sp),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Address of the current top-of-stack word boundary.
    always_comb slot = STK_ORG + ADDR_W'(sp);

    // Next-state and output decode for the call/return sequence.
    always_comb begin
        state_nx    = state;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        cap_wr_en   = 1'b0;
        cap_wr_sel  = REG_ROOT;
        cap_wr_data = '0;
        pc_wr_en    = 1'b0;
        pc_wr_data  = '0;
        push        = 1'b0;
        pop         = 1'b0;
        done        = 1'b0;
        fault       = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (op_start) begin
                    if (op_ret)
                        state_nx = stk_empty ? S_FAULT : S_POP_CD;
                    else
                        state_nx = (pre_ok && !stk_full) ? S_FETCH : S_FAULT;
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = fetch_q;
                state_nx = exec_ok ? S_PUSH_PC : S_FAULT;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot;
                mem_wdata = CAP_W'(cur_pc);
                state_nx  = S_PUSH_RT;
            end
            S_PUSH_RT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot + ADDR_W'(1);
                mem_wdata = cur_root;
                state_nx  = S_PUSH_CD;
            end
            S_PUSH_CD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot + ADDR_W'(2);
                mem_wdata = cur_code;
                push      = 1'b1;
                state_nx  = S_LOAD_RT;
            end
            S_LOAD_RT: begin
                cap_wr_en   = 1'b1;
                cap_wr_sel  = REG_ROOT;
                cap_wr_data = root_q;
                state_nx    = S_LOAD_CD;
            end
            S_LOAD_CD: begin
                cap_wr_en   = 1'b1;
                cap_wr_sel  = REG_CODE;
                cap_wr_data = code_q;
                pc_wr_en    = 1'b1;
                pc_wr_data  = '0;
                done        = 1'b1;
                state_nx    = S_IDLE;
            end
            S_POP_CD: begin
                mem_req     = 1'b1;
                mem_addr    = slot - ADDR_W'(1);
                cap_wr_en   = 1'b1;
                cap_wr_sel  = REG_CODE;
                cap_wr_data = mem_rdata;
                state_nx    = S_POP_RT;
            end
            S_POP_RT: begin
                mem_req     = 1'b1;
                mem_addr    = slot - ADDR_W'(2);
                cap_wr_en   = 1'b1;
                cap_wr_sel  = REG_ROOT;
                cap_wr_data = mem_rdata;
                state_nx    = S_POP_PC;
            end
            S_POP_PC: begin
                mem_req    = 1'b1;
                mem_addr   = slot - ADDR_W'(3);
                pc_wr_en   = 1'b1;
                pc_wr_data = mem_rdata[ADDR_W-1:0];
                pop        = 1'b1;
                done       = 1'b1;
                state_nx   = S_IDLE;
            end
            S_FAULT: begin
                done     = 1'b1;
                fault    = 1'b1;
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Capture the call target: root capability and fetch address at start,
    // fetched code capability during the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q  <= '0;
            code_q  <= '0;
            fetch_q <= '0;
        end else begin
            if (state == S_IDLE && op_start && !op_ret) begin
                root_q  <= gate_root;
                fetch_q <= gate_addr;
            end
            if (state == S_FETCH)
                code_q <= mem_rdata;
        end
    end

    // Busy whenever a sequence is under way.
    always_comb busy = (state != S_IDLE);

    // R7
    gp_regs_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr_en |-> (cap_wr_sel == REG_ROOT || cap_wr_sel == REG_CODE));
    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!cap_wr_en && !pc_wr_en && !mem_req));
    // R3
    stack_write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr >= STK_ORG &&
                                 mem_addr < STK_ORG + ADDR_W'(STK_WORDS)));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    refuse_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_start && !op_ret && !pre_ok) |=> (fault && !mem_req));
endmodule

// File: tb/domain_call_seq_tb.sv
module domain_call_seq_tb;
    localparam int A      = 8;
    localparam int W      = 6 + 2 * A;
    localparam int FRAMES = 2;
    localparam int SBASE  = 192;
    localparam logic [5:0] RT_EXEC  = 6'b000001;
    localparam logic [5:0] RT_RDATA = 6'b000100;
    localparam logic [5:0] RT_ENTER = 6'b001000;
    localparam logic [5:0] RT_RCAP  = 6'b100000;
    localparam logic [W-1:0] INIT_ROOT = {6'b100100, 8'h05, 8'h06};
    localparam logic [W-1:0] INIT_CODE = {6'b000001, 8'h07, 8'h08};

    typedef struct packed {
        logic       ret;
        logic [5:0] rts;
        logic [7:0] base;
        logic [7:0] lim;
        logic [7:0] off;
        logic       efault;
        logic [3:0] elat;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b0, RT_ENTER, 8'h40, 8'h04, 8'h00, 1'b0, 4'd6},
        '{1'b0, RT_RCAP,  8'h40, 8'h04, 8'h00, 1'b1, 4'd1},
        '{1'b0, RT_ENTER, 8'h40, 8'h04, 8'h04, 1'b1, 4'd1},
        '{1'b0, RT_ENTER, 8'h40, 8'h04, 8'h01, 1'b1, 4'd2},
        '{1'b0, RT_ENTER, 8'h40, 8'h04, 8'h02, 1'b0, 4'd6},
        '{1'b0, RT_ENTER, 8'h40, 8'h04, 8'h00, 1'b1, 4'd1},
        '{1'b1, 6'd0,     8'h00, 8'h00, 8'h00, 1'b0, 4'd3},
        '{1'b1, 6'd0,     8'h00, 8'h00, 8'h00, 1'b0, 4'd3},
        '{1'b1, 6'd0,     8'h00, 8'h00, 8'h00, 1'b1, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, op_ret = 1'b0;
    logic [W-1:0] enter_cap = '0;
    logic [A-1:0] call_off = '0;
    logic busy, done, fault, mem_req, mem_we, cap_wr_en, pc_wr_en;
    logic [A-1:0] mem_addr, pc_wr_data;
    logic [W-1:0] mem_wdata, mem_rdata, cap_wr_data;
    logic [2:0] cap_wr_sel;
    logic [W-1:0] c6, c7;
    logic [A-1:0] pc;
    logic [W-1:0] mem [256];
    logic pc_set_req = 1'b0;
    logic [A-1:0] pc_set_val = '0;
    int checks = 0, errors = 0, gp_hits = 0, rd_cnt = 0, rd_bad = 0, cycles = 0;
    logic [A-1:0] rd_lo = '0, rd_hi = '0, rd_exp = '0;
    logic [A-1:0] m_pc [FRAMES];
    logic [W-1:0] m_rt [FRAMES];
    logic [W-1:0] m_cd [FRAMES];
    int depth = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    domain_call_seq #(.ADDR_W(A), .STK_FRAMES(FRAMES), .STK_BASE(SBASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_ret(op_ret),
        .enter_cap(enter_cap), .call_off(call_off), .busy(busy), .done(done),
        .fault(fault), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_root(c6),
        .cur_code(c7), .cur_pc(pc), .cap_wr_en(cap_wr_en),
        .cap_wr_sel(cap_wr_sel), .cap_wr_data(cap_wr_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data)
    );

    assign mem_rdata = mem[mem_addr];

    // Bench memory, register file and access monitors.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we && mem_addr >= rd_lo && mem_addr < rd_hi) begin
            rd_cnt <= rd_cnt + 1;
            if (mem_addr != rd_exp) rd_bad <= rd_bad + 1;
        end
        if (!rst_n) begin
            c6 <= INIT_ROOT;
            c7 <= INIT_CODE;
            pc <= 8'h33;
        end else begin
            if (cap_wr_en) begin
                if (cap_wr_sel == 3'd6) c6 <= cap_wr_data;
                else if (cap_wr_sel == 3'd7) c7 <= cap_wr_data;
                else gp_hits <= gp_hits + 1;
            end
            if (pc_wr_en) pc <= pc_wr_data;
            else if (pc_set_req) pc <= pc_set_val;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk(input logic [5:0] r, input logic [7:0] b,
                                        input logic [7:0] l);
        return {r, b, l};
    endfunction

    // Issue one operation; returns observed latency and fault.
    task automatic issue(input logic ret, input logic [W-1:0] cap,
                         input logic [A-1:0] off, output int lat, output logic flt);
        @(negedge clk);
        op_ret = ret; enter_cap = cap; call_off = off; op_start = 1'b1;
        rd_cnt = 0; rd_bad = 0;
        lat = 0; flt = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            op_start = 1'b0;
            if (done) begin
                flt = fault;
                break;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int lat;
        logic flt;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h40] = mk(RT_EXEC | RT_RDATA, 8'h10, 8'h20);
        mem[8'h41] = mk(RT_RDATA, 8'h50, 8'h08);
        mem[8'h42] = mk(RT_EXEC, 8'h60, 8'h10);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !fault, "R9", "idle flags after reset", {busy, done, fault}, 0);
        chk(!mem_req && !cap_wr_en && !pc_wr_en, "R9", "no request after reset",
            {mem_req, cap_wr_en, pc_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            vec_t v;
            logic [W-1:0] cap, x6, x7;
            logic [A-1:0] xpc, pc0;
            logic efl;
            int pre_reads;
            v = VEC[i];
            cap = mk(v.rts, v.base, v.lim);
            pc_set_val = 8'h10 + 8'(i); pc_set_req = 1'b1;
            @(negedge clk);
            pc_set_req = 1'b0;
            pc0 = pc; x6 = c6; x7 = c7; xpc = pc;
            rd_lo = v.base; rd_hi = v.base + v.lim; rd_exp = v.base + v.off;
            pre_reads = 0;
            if (!v.ret) begin
                logic pre;
                pre = v.rts[3] && (v.off < v.lim) && (depth < FRAMES);
                pre_reads = (v.rts[3] && (v.off < v.lim) && (depth < FRAMES)) ? 1 : 0;
                efl = !pre || !mem[v.base + v.off][W-6];
                if (!efl) begin
                    m_pc[depth] = pc0; m_rt[depth] = c6; m_cd[depth] = c7;
                    x6 = mk(RT_RCAP, v.base, v.lim);
                    x7 = mem[v.base + v.off];
                    xpc = '0;
                end
            end else begin
                efl = (depth == 0);
                if (!efl) begin
                    x6 = m_rt[depth-1]; x7 = m_cd[depth-1]; xpc = m_pc[depth-1];
                end
            end
            issue(v.ret, cap, v.off, lat, flt);
            chk(flt == efl && flt == v.efault, efl ? "R6" : "R1", $sformatf("fault vec %0d", i), flt, efl);
            chk(lat == int'(v.elat), "R8", $sformatf("latency vec %0d", i), lat, v.elat);
            chk(c6 == x6, v.ret ? "R5" : "R4", $sformatf("root reg vec %0d", i), c6, x6);
            chk(c7 == x7, v.ret ? "R5" : "R4", $sformatf("code reg vec %0d", i), c7, x7);
            chk(pc == xpc, v.ret ? "R5" : "R4", $sformatf("pc vec %0d", i), pc, xpc);
            if (!v.ret) begin
                // R2: exactly one read of the root block, at base+offset
                chk(rd_cnt == pre_reads && rd_bad == 0, "R2", $sformatf("root reads vec %0d", i),
                    rd_cnt, pre_reads);
            end
            if (!efl) begin
                if (!v.ret) begin
                    int b;
                    b = SBASE + 3 * depth;
                    chk(mem[b][A-1:0] == pc0 && mem[b][W-1:A] == '0, "R3",
                        $sformatf("pushed pc vec %0d", i), mem[b][A-1:0], pc0);
                    chk(mem[b+1] == m_rt[depth], "R3", $sformatf("pushed root vec %0d", i),
                        mem[b+1], m_rt[depth]);
                    chk(mem[b+2] == m_cd[depth], "R3", $sformatf("pushed code vec %0d", i),
                        mem[b+2], m_cd[depth]);
                    depth++;
                end else depth--;
            end
        end

        // R9: reset in the middle of a call empties the stack
        pc_set_val = 8'h55; pc_set_req = 1'b1;
        @(negedge clk);
        pc_set_req = 1'b0;
        op_ret = 1'b0; enter_cap = mk(RT_ENTER, 8'h40, 8'h04); call_off = 8'h00;
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy, "R8", "busy mid call", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy, "R9", "idle after mid-op reset", busy, 0);
        issue(1'b1, '0, '0, lat, flt);
        chk(flt && lat == 1, "R9", "return after reset faults (empty stack)", {flt, 4'(lat)}, 5'h11);
        chk(gp_hits == 0, "R7", "writes to registers 0..5", gp_hits, 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles > 20000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule